// File: doc/BRIEF.md
# Performance-Monitor Parity Error Counter with Snapshot

The block totals received parity errors for performance monitoring, one frame at a time. Each cycle, a frame-valid strobe may come with that frame's error count. A mode input chooses what is added. In bit mode the counter adds the frame's error count itself. In block mode it adds one for each frame whose count is non-zero. A second mode input chooses what happens at the top of the 16-bit range. In saturate mode the counter stops at the maximum. In rollover mode it wraps.

A periodic monitoring strobe closes each period. A small two-state machine follows the strobe. In state ST_LOW (strobe last seen low), a high strobe takes the transition ST_LOW->ST_HIGH and issues one transfer. In state ST_HIGH, a low strobe takes the transition ST_HIGH->ST_LOW, and a high strobe keeps the state without a transfer. A transfer copies the running count into a holding register that software can read. The counter then starts the new period from the current cycle's increment, so no error is lost at the boundary. Reset puts the machine in ST_LOW.

Top module: `pm_err_counter`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears count_out and hold_out to 0 and puts the edge machine in ST_LOW.
- R2: In bit mode (mode_block=0), a cycle with frame_valid=1 adds frame_err (0..255) to the running count, visible on count_out after that clock edge.
- R3: In block mode (mode_block=1), a cycle with frame_valid=1 adds 1 when frame_err is non-zero and adds 0 when it is zero.
- R4: A cycle with frame_valid=0 adds nothing, whatever frame_err holds.
- R5: With mode_sat=1, a sum above 0xFFFF gives 0xFFFF, and the count then stays at 0xFFFF.
- R6: With mode_sat=0, the sum wraps modulo 2^16.
- R7: When pm_strobe is high in state ST_LOW, hold_out takes the count_out value from before that edge. The new value appears after the edge.
- R8: On a transfer edge, count_out becomes that cycle's increment alone: the frame_err value, the block-mode 0 or 1, or 0 when frame_valid=0.
- R9: hold_out changes only on a transfer. A strobe held high for several cycles makes exactly one transfer.
- R10: A strobe that is already high in the first cycle after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Frame error count valid this cycle |
| frame_err | input | 8 | Parity errors found in the frame |
| mode_block | input | 1 | 1: count errored frames, 0: count bit errors |
| mode_sat | input | 1 | 1: saturate at maximum, 0: wrap around |
| pm_strobe | input | 1 | Periodic monitoring strobe; rising edge makes a snapshot |
| count_out | output | 16 | Running count of the current period |
| hold_out | output | 16 | Count of the last completed period |

## Verification
The bench steers the count into the top of its range in both overflow modes. A design that clamps at the wrong value, or wraps while in saturate mode, then shows a wrong count_out. Transfers land at many different counts, and errored frames arrive on the transfer edge itself. A design that clears the counter to zero there drops that cycle's errors, and one that adds them to the old total carries errors into the next period. The bench also holds the strobe high for several cycles and raises it in the first cycle after reset. A level-triggered transfer or a missed first edge then shows as a wrong hold_out. Modes change in the middle of a period, and frames with zero errors and invalid frames carrying non-zero counts are mixed in, to catch block-mode and frame-valid gating faults.

// File: rtl/pm_cnt_pkg.sv
package pm_cnt_pkg;
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } strobe_state_t;
endpackage

// File: rtl/pm_edge_fsm.sv
module pm_edge_fsm
    import pm_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pm_strobe,
    output logic take
);
    strobe_state_t state_q;
    strobe_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (pm_strobe)  state_d = ST_HIGH;
            ST_HIGH: if (!pm_strobe) state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        take = 1'b0;
        unique case (state_q)
            ST_LOW:  take = pm_strobe;
            ST_HIGH: take = 1'b0;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/pm_incr_sel.sv
module pm_incr_sel #(
    parameter int ERR_W = 8
) (
    input  logic             frame_valid,
    input  logic [ERR_W-1:0] frame_err,
    input  logic             mode_block,
    output logic [ERR_W-1:0] incr
);
    always_comb begin
        if (!frame_valid)    incr = '0;
        else if (mode_block) incr = {{(ERR_W-1){1'b0}}, |frame_err};
        else                 incr = frame_err;
    end
endmodule

// File: rtl/pm_accum.sv
module pm_accum #(
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] incr,
    input  logic             mode_sat,
    input  logic             take,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] hold_q
);
    localparam int SUM_W = CNT_W + 1;
    localparam int PAD_W = SUM_W - ERR_W;

    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        sum = {1'b0, count_q} + {{PAD_W{1'b0}}, incr};
        if (take)
            next_cnt = {{(CNT_W-ERR_W){1'b0}}, incr};
        else if (sum[CNT_W] && mode_sat)
            next_cnt = '1;
        else
            next_cnt = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            hold_q  <= '0;
        end else begin
            count_q <= next_cnt;
            if (take) hold_q <= count_q;
        end
    end
endmodule

// File: rtl/pm_err_counter.sv
module pm_err_counter #(
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic [ERR_W-1:0] frame_err,
    input  logic             mode_block,
    input  logic             mode_sat,
    input  logic             pm_strobe,
    output logic [CNT_W-1:0] count_out,
    output logic [CNT_W-1:0] hold_out
);
    logic             take;
    logic [ERR_W-1:0] incr;

    pm_edge_fsm u_edge (
        .clk(clk), .rst_n(rst_n), .pm_strobe(pm_strobe), .take(take)
    );

    pm_incr_sel #(.ERR_W(ERR_W)) u_sel (
        .frame_valid(frame_valid), .frame_err(frame_err),
        .mode_block(mode_block), .incr(incr)
    );

    pm_accum #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .incr(incr), .mode_sat(mode_sat),
        .take(take), .count_q(count_out), .hold_q(hold_out)
    );
endmodule

// File: rtl/pm_err_counter_chk.sv
module pm_err_counter_chk #(
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_valid,
    input logic [ERR_W-1:0] frame_err,
    input logic             mode_block,
    input logic             mode_sat,
    input logic             pm_strobe,
    input logic [CNT_W-1:0] count_out,
    input logic [CNT_W-1:0] hold_out
);
    logic prev_stb;
    logic rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_stb <= 1'b0;
        else        prev_stb <= pm_strobe;
    end
    assign rise = pm_strobe && !prev_stb;

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(hold_out));

    a_r7_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (hold_out == $past(count_out)));

    a_r4_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !rise) |=> $stable(count_out));

    a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sat && (&count_out) && !rise) |=> (&count_out));

    a_r3_block_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_block && !mode_sat && !rise) |=>
        ((count_out == $past(count_out)) ||
         (count_out == $past(count_out) + 1'b1)));

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !frame_valid) |=> (count_out == '0));
endmodule

bind pm_err_counter pm_err_counter_chk #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_err(frame_err),
    .mode_block(mode_block), .mode_sat(mode_sat), .pm_strobe(pm_strobe),
    .count_out(count_out), .hold_out(hold_out)
);

// File: tb/pm_err_counter_bench.sv
module pm_err_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [7:0]  frame_err = 8'd0;
    logic        mode_block = 1'b0;
    logic        mode_sat = 1'b0;
    logic        pm_strobe = 1'b0;
    logic [15:0] count_out;
    logic [15:0] hold_out;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    int exp_hold = 0;
    logic exp_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pm_err_counter u_pm_err_counter (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_err(frame_err),
        .mode_block(mode_block), .mode_sat(mode_sat), .pm_strobe(pm_strobe),
        .count_out(count_out), .hold_out(hold_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // inputs set at negedge; model advanced; compared at following negedge
    task automatic step(input logic fv, input logic [7:0] e, input logic blk,
                        input logic sat, input logic stb);
        int inc;
        int sum;
        logic rise;
        string ctag;
        string htag;
        frame_valid = fv; frame_err = e; mode_block = blk;
        mode_sat = sat; pm_strobe = stb;
        inc = !fv ? 0 : (blk ? (e != 0 ? 1 : 0) : int'(e));
        rise = stb && !exp_prev;
        exp_prev = stb;
        sum = exp_cnt + inc;
        if (rise) begin
            exp_hold = exp_cnt; exp_cnt = inc; ctag = "R8"; htag = "R7";
        end else begin
            htag = "R9";
            if (!fv) ctag = "R4";
            else if (sum > 65535 && sat) ctag = "R5";
            else if (sum > 65535) ctag = "R6";
            else if (blk) ctag = "R3";
            else ctag = "R2";
            if (sum > 65535) exp_cnt = sat ? 65535 : sum - 65536;
            else exp_cnt = sum;
        end
        @(posedge clk);
        @(negedge clk);
        check(ctag, int'(count_out), exp_cnt);
        check(htag, int'(hold_out), exp_hold);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: strobe already high while in reset
        pm_strobe = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", int'(count_out), 0);
        check("R1", int'(hold_out), 0);
        rst_n = 1'b1;
        exp_prev = 1'b0;
        step(1'b1, 8'd9, 1'b0, 1'b1, 1'b1);  // first-cycle edge: hold=0, count=9
        check("R10", int'(count_out), 9);
        step(1'b1, 8'd5, 1'b0, 1'b1, 1'b1);  // still high: accumulate
        step(1'b1, 8'd5, 1'b0, 1'b1, 1'b0);
        step(1'b0, 8'd7, 1'b0, 1'b1, 1'b1);  // edge with no frame
        check("R10", int'(hold_out), 19);

        // R5: saturate in bit mode
        for (int i = 0; i < 270; i++) step(1'b1, 8'd255, 1'b0, 1'b1, 1'b0);
        check("R5", int'(count_out), 65535);
        step(1'b1, 8'd1, 1'b1, 1'b1, 1'b0);
        // R6: wrap from max in block mode then bit mode
        step(1'b1, 8'd3, 1'b1, 1'b0, 1'b0);
        check("R6", int'(count_out), 0);
        step(1'b1, 8'd0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 8'd200, 1'b0, 1'b0, 1'b0);
        check("R4", int'(count_out), 0);

        // sweep: every mode combination, patterned errors, periodic strobes
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] e;
            logic fv;
            logic stb;
            e = 8'((i * 37 + (i >> 3)) % 256);
            if (i % 11 == 0) e = 8'd0;
            fv = (i % 7) != 3;
            stb = (i % 700) >= 695;
            step(fv, e, 1'(i / 500 % 2), 1'(i / 1000 % 2), stb);
        end

        // strobe held high for many cycles makes one transfer (R9)
        for (int i = 0; i < 10; i++) step(1'b1, 8'd4, 1'b0, 1'b0, 1'b1);
        step(1'b1, 8'd4, 1'b0, 1'b0, 1'b0);

        // async reset mid-run (R1)
        #2 rst_n = 1'b0;
        #1 check("R1", int'(count_out), 0);
        check("R1", int'(hold_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0; exp_hold = 0; exp_prev = 1'b0;
        step(1'b1, 8'd2, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule